// File: doc/BRIEF.md
# Multi-UI Coarse Phase Tracker

This block follows the phase difference between a reference clock and a feedback clock in whole unit intervals, where one UI is one reference period. Each reference edge strobe moves the count up by one and each feedback edge strobe moves it down by one. The result is a signed error that can stay valid across thousands of UI, instead of wrapping inside a single period. The block is meant to sit next to a fine phase detector in a digital PLL. It feeds the loop with the multi-period part of the error, so that jitter or wander well beyond half a UI does not make the loop slip cycles.

A configuration byte selects the range and turns the two functions on. A 4-bit code picks a symmetric limit. A wide-range enable lets the reported error run up to that limit, and without it the error stays within one UI. A separate enable arms a coarse phase-loss alarm that uses the same limit. The alarm watches an unclamped copy of the count, so it works whether or not wide-range tracking is on. Once raised, it stays up until it is cleared.

Top module: `coarse_ui_tracker`

## Requirements
- R1: After reset, `ui_err` is 0, `clamped` is 0 and `phase_loss` is 0. The stored configuration holds 8'h85, which gives the alarm enabled, wide range off and limit code 5 (limit 63).
- R2: A reference strobe alone raises the tracked error by one, and a feedback strobe alone lowers it by one. Both strobes in the same cycle leave it unchanged. The new value appears on `ui_err` after the clock edge that samples the strobes.
- R3: A limit code n from 0 to 11 gives the limit 2^(n+1)-1 UI. Codes 12 to 15 all give 8191 UI.
- R4: With wide range enabled (config bit 6 = 1), `ui_err` saturates at plus or minus the limit and does not wrap. `clamped` is 1 exactly when the registered error sits at either bound.
- R5: With wide range disabled, `ui_err` saturates at plus or minus 1, and `clamped` marks the value at either bound.
- R6: With the alarm enabled (config bit 7 = 1), `phase_loss` rises after the edge at which the magnitude of the unclamped error first exceeds the limit. This holds whether wide range is on or off.
- R7: With the alarm disabled, `phase_loss` is 0 from the edge after the disable takes effect.
- R8: `phase_loss` stays set after the error returns inside the limit. A `clr_loss` pulse clears it at the next edge and takes priority over a new set. The flag rises again one edge later if the error is still beyond the limit.
- R9: When `cfg_we` is high, a clock edge stores `cfg_data`. Bit 7 is the alarm enable, bit 6 the wide-range enable and bits 3:0 the limit code. The stored value governs the updates from the following edge on. When the range narrows, the error is pulled inside the new bound at that following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_edge | input | 1 | One-cycle strobe per reference clock edge |
| fb_edge | input | 1 | One-cycle strobe per feedback clock edge |
| clr_loss | input | 1 | Synchronous clear of the phase-loss flag |
| cfg_we | input | 1 | Store `cfg_data` at this edge |
| cfg_data | input | 8 | Configuration: bit 7 alarm enable, bit 6 wide range, bits 3:0 limit code |
| ui_err | output | 15 | Signed tracked error in whole UI |
| clamped | output | 1 | Tracked error is at a range bound |
| phase_loss | output | 1 | Coarse phase-loss alarm |

## Verification
A strobe applied before an edge shows up on `ui_err` and `clamped` right after that edge. `phase_loss` responds at the same edge, because it is judged on the next-state count. A configuration write acts one edge later, since the write edge still uses the old setting. The bench drives every input at a falling edge and reads the outputs at the next falling edge, so each check lands exactly one register stage after its stimulus. The expected values for the write-then-observe cases are placed one vector later than the write itself.

// File: rtl/ct_pkg.sv
package ct_pkg;

  // Symmetric limit in UI for a range code; codes past max_exp are held at max_exp.
  function automatic int unsigned ct_range_of(input int unsigned code,
                                              input int unsigned max_exp);
    int unsigned e;
    e = (code > max_exp) ? max_exp : code;
    return (32'd2 << e) - 32'd1;
  endfunction

  // Net count change for one cycle of edge strobes.
  function automatic logic signed [1:0] ct_delta(input logic up, input logic dn);
    if (up && !dn)      return 2'sb01;
    else if (dn && !up) return 2'sb11;
    else                return 2'sb00;
  endfunction

endpackage

// File: rtl/ct_cfg_reg.sv
module ct_cfg_reg #(
  parameter int          CODE_W  = 4,
  parameter logic [7:0]  RST_VAL = 8'h85
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        din,
  output logic              loss_en,
  output logic              wide_en,
  output logic [CODE_W-1:0] code
);
  logic spare_unused;
  assign spare_unused = ^din[5:CODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loss_en <= RST_VAL[7];
      wide_en <= RST_VAL[6];
      code    <= RST_VAL[CODE_W-1:0];
    end else if (we) begin
      loss_en <= din[7];
      wide_en <= din[6];
      code    <= din[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/ct_limit_dec.sv
module ct_limit_dec
  import ct_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int MAX_EXP = 12,
  parameter int LIM_W   = MAX_EXP + 1
) (
  input  logic [CODE_W-1:0] code,
  input  logic              wide_en,
  output logic [LIM_W-1:0]  limit,
  output logic [LIM_W-1:0]  trk_bound
);
  always_comb begin
    limit     = LIM_W'(ct_range_of(32'(code), 32'(MAX_EXP)));
    trk_bound = wide_en ? limit : LIM_W'(1);
  end
endmodule

// File: rtl/ct_sat_counter.sv
module ct_sat_counter #(
  parameter int W = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [1:0]   delta,
  input  logic [W-2:0]        bound,
  output logic signed [W-1:0] value,
  output logic signed [W-1:0] next_value
);
  localparam int XW = W + 1;

  logic signed [XW-1:0] sum_x, hi_x, lo_x, pick_x;

  always_comb begin
    sum_x = XW'(value) + XW'(delta);
    hi_x  = $signed({2'b00, bound});
    lo_x  = -hi_x;
    if (sum_x > hi_x)      pick_x = hi_x;
    else if (sum_x < lo_x) pick_x = lo_x;
    else                   pick_x = sum_x;
    next_value = $signed(pick_x[W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= next_value;
  end
endmodule

// File: rtl/ct_loss_det.sv
module ct_loss_det #(
  parameter int W     = 15,
  parameter int LIM_W = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                clr,
  input  logic signed [W-1:0] raw_next,
  input  logic [LIM_W-1:0]    limit,
  output logic                beyond,
  output logic                flag
);
  logic [W-1:0] mag;

  always_comb begin
    mag    = raw_next[W-1] ? $unsigned(-raw_next) : $unsigned(raw_next);
    beyond = mag > W'(limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= en & ~clr & (flag | beyond);
  end
endmodule

// File: rtl/coarse_ui_tracker.sv
module coarse_ui_tracker
  import ct_pkg::*;
#(
  parameter int         CODE_W  = 4,
  parameter int         MAX_EXP = 12,
  parameter logic [7:0] CFG_RST = 8'h85,
  localparam int        ERR_W   = MAX_EXP + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_edge,
  input  logic                    fb_edge,
  input  logic                    clr_loss,
  input  logic                    cfg_we,
  input  logic [7:0]              cfg_data,
  output logic signed [ERR_W-1:0] ui_err,
  output logic                    clamped,
  output logic                    phase_loss
);
  localparam int               LIM_W     = MAX_EXP + 1;
  localparam int               BND_W     = ERR_W - 1;
  localparam int               N_CNT     = 2;
  localparam logic [BND_W-1:0] RAW_BOUND = BND_W'(1) << (MAX_EXP + 1);

  logic              loss_en_q, wide_en_q;
  logic [CODE_W-1:0] code_q;
  logic [LIM_W-1:0]  limit, trk_bound;
  logic signed [1:0] step;
  logic              beyond;

  logic [BND_W-1:0]        cnt_bound [N_CNT];
  logic signed [ERR_W-1:0] cnt_val   [N_CNT];
  logic signed [ERR_W-1:0] cnt_nxt   [N_CNT];

  logic signed [ERR_W-1:0] trk_err, trk_next, raw_err, raw_next, bnd_pos;
  logic                    clamped_q;

  ct_cfg_reg #(.CODE_W(CODE_W), .RST_VAL(CFG_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .din(cfg_data),
    .loss_en(loss_en_q), .wide_en(wide_en_q), .code(code_q)
  );

  ct_limit_dec #(.CODE_W(CODE_W), .MAX_EXP(MAX_EXP), .LIM_W(LIM_W)) u_dec (
    .code(code_q), .wide_en(wide_en_q), .limit(limit), .trk_bound(trk_bound)
  );

  assign step         = ct_delta(ref_edge, fb_edge);
  assign cnt_bound[0] = BND_W'(trk_bound);
  assign cnt_bound[1] = RAW_BOUND;

  // Counter 0 tracks the reported error; counter 1 keeps the unclamped count for the alarm.
  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    ct_sat_counter #(.W(ERR_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .delta(step), .bound(cnt_bound[k]),
      .value(cnt_val[k]), .next_value(cnt_nxt[k])
    );
  end

  assign trk_err  = cnt_val[0];
  assign trk_next = cnt_nxt[0];
  assign raw_err  = cnt_val[1];
  assign raw_next = cnt_nxt[1];
  assign bnd_pos  = $signed({2'b00, trk_bound});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clamped_q <= 1'b0;
    else        clamped_q <= (trk_next == bnd_pos) || (trk_next == -bnd_pos);
  end

  ct_loss_det #(.W(ERR_W), .LIM_W(LIM_W)) u_loss (
    .clk(clk), .rst_n(rst_n), .en(loss_en_q), .clr(clr_loss),
    .raw_next(raw_next), .limit(limit), .beyond(beyond), .flag(phase_loss)
  );

  assign ui_err  = trk_err;
  assign clamped = clamped_q;
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
  parameter int ERR_W = 15,
  parameter int LIM_W = 13
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ref_edge,
  input logic                    fb_edge,
  input logic                    clr_loss,
  input logic                    cfg_we,
  input logic signed [ERR_W-1:0] ui_err,
  input logic signed [ERR_W-1:0] raw_err,
  input logic                    clamped,
  input logic                    phase_loss,
  input logic [LIM_W-1:0]        trk_bound,
  input logic                    loss_en_q,
  input logic                    wide_en_q,
  input logic                    beyond
);
  int err_i, bnd_i, raw_i;
  logic in_open;
  assign err_i   = int'(ui_err);
  assign raw_i   = int'(raw_err);
  assign bnd_i   = int'(trk_bound);
  assign in_open = (err_i < bnd_i) && (err_i > -bnd_i);

  // R2: single reference strobe steps up by one when not at a bound
  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && !fb_edge && !cfg_we && in_open) |=> (err_i == $past(err_i) + 1));

  // R2: single feedback strobe steps down by one when not at a bound
  assert_dn_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_edge && !ref_edge && !cfg_we && in_open) |=> (err_i == $past(err_i) - 1));

  // R2: coincident strobes leave both counts alone
  assert_both_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && fb_edge && !cfg_we) |=> ($stable(ui_err) && $stable(raw_err)));

  // R4: tracked error stays inside the bound when the setting is steady
  assert_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we) |=> (err_i <= bnd_i && err_i >= -bnd_i));

  // R4: clamp flag agrees with the error sitting on a bound
  assert_clamp_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we) |=> (clamped == (err_i == bnd_i || err_i == -bnd_i)));

  // R5: narrow mode confines the error to one UI
  assert_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_en_q && !cfg_we) |=> (err_i <= 1 && err_i >= -1));

  // R6: an excursion past the limit raises the alarm at the next edge
  assert_loss_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loss_en_q && !clr_loss && beyond) |=> phase_loss);

  // R6: the unclamped count follows single strobes while far from saturation
  assert_raw_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && !fb_edge && raw_i < 4096 && raw_i > -4096) |=> (raw_i == $past(raw_i) + 1));

  // R7: alarm disabled keeps the flag low
  assert_loss_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!loss_en_q) |=> !phase_loss);

  // R8: clear wins over a set
  assert_loss_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_loss |=> !phase_loss);
endmodule

bind coarse_ui_tracker ct_checker #(.ERR_W(ERR_W), .LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
  .clr_loss(clr_loss), .cfg_we(cfg_we), .ui_err(ui_err), .raw_err(raw_err),
  .clamped(clamped), .phase_loss(phase_loss), .trk_bound(trk_bound),
  .loss_en_q(loss_en_q), .wide_en_q(wide_en_q), .beyond(beyond)
);

// File: tb/sim_coarse_ui_tracker.sv
module sim_coarse_ui_tracker;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst_n, ref_edge, fb_edge, clr_loss, cfg_we;
  logic [7:0]         cfg_data;
  logic signed [14:0] ui_err;
  logic               clamped, phase_loss;

  int checks = 0;
  int errors = 0;

  coarse_ui_tracker u0 (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .clr_loss(clr_loss), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .ui_err(ui_err), .clamped(clamped), .phase_loss(phase_loss)
  );

  typedef struct packed {
    logic              we;
    logic [7:0]        data;
    logic              rf;
    logic              fb;
    logic              clr;
    logic signed [15:0] err;
    logic              cl;
    logic              ls;
    logic [3:0]        req;
  } vec_t;

  // Config 8'hC1: alarm on, wide on, code 1 (limit 3). Each row is one cycle.
  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hC1, 1'b0, 1'b0, 1'b0,  16'sd0, 1'b0, 1'b0, 4'd9},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0,  16'sd1, 1'b0, 1'b0, 4'd2},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0,  16'sd2, 1'b0, 1'b0, 4'd2},
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0,  16'sd2, 1'b0, 1'b0, 4'd2},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0,  16'sd3, 1'b1, 1'b0, 4'd4},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0,  16'sd3, 1'b1, 1'b1, 4'd6},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0,  16'sd2, 1'b0, 1'b1, 4'd8},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1,  16'sd2, 1'b0, 1'b0, 4'd8},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0,  16'sd1, 1'b0, 1'b0, 4'd2},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0,  16'sd0, 1'b0, 1'b0, 4'd2},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, -16'sd1, 1'b0, 1'b0, 4'd2},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, -16'sd2, 1'b0, 1'b0, 4'd2},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, -16'sd3, 1'b1, 1'b0, 4'd4},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, -16'sd3, 1'b1, 1'b0, 4'd4},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, -16'sd3, 1'b1, 1'b1, 4'd6},
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b1, -16'sd3, 1'b1, 1'b0, 4'd8},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, -16'sd3, 1'b1, 1'b1, 4'd8},
    '{1'b1, 8'h41, 1'b0, 1'b0, 1'b0, -16'sd3, 1'b1, 1'b1, 4'd9},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, -16'sd3, 1'b1, 1'b0, 4'd7},
    '{1'b1, 8'h01, 1'b0, 1'b0, 1'b0, -16'sd3, 1'b1, 1'b0, 4'd9},
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, -16'sd1, 1'b1, 1'b0, 4'd5},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0,  16'sd0, 1'b0, 1'b0, 4'd5},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0,  16'sd1, 1'b1, 1'b0, 4'd5},
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0,  16'sd1, 1'b1, 1'b0, 4'd5}
  };

  task automatic drive(input logic we, input logic [7:0] d,
                       input logic r, input logic f, input logic c);
    cfg_we = we; cfg_data = d; ref_edge = r; fb_edge = f; clr_loss = c;
    @(negedge clk);
    cfg_we = 1'b0; ref_edge = 1'b0; fb_edge = 1'b0; clr_loss = 1'b0;
  endtask

  task automatic expect_out(input string tag, input int e_err,
                            input logic e_cl, input logic e_ls);
    checks++;
    if (int'(ui_err) != e_err || clamped !== e_cl || phase_loss !== e_ls) begin
      errors++;
      $display("FAIL %s: err=%0d clamped=%0b loss=%0b expected err=%0d clamped=%0b loss=%0b",
               tag, int'(ui_err), clamped, phase_loss, e_err, e_cl, e_ls);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_data = 8'h00;
    ref_edge = 1'b0; fb_edge = 1'b0; clr_loss = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    expect_out("R1 reset state", 0, 1'b0, 1'b0);

    // Table walk: stepping, coincident strobes, saturation, alarm, clear, reconfig (R2 R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].we, VEC[i].data, VEC[i].rf, VEC[i].fb, VEC[i].clr);
      expect_out($sformatf("R%0d vector %0d", VEC[i].req, i),
                 int'(VEC[i].err), VEC[i].cl, VEC[i].ls);
    end

    // R1 default config: narrow tracking, limit 63, alarm enabled
    do_reset();
    repeat (63) drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    expect_out("R1 default after 63 refs", 1, 1'b1, 1'b0);
    drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    expect_out("R6 default after 64 refs", 1, 1'b1, 1'b1);

    // R3: every limit code, wide range and alarm on
    for (int code = 0; code < 16; code++) begin
      int lim;
      lim = 1;
      for (int j = 0; j < code && j < 12; j++) lim = lim * 2 + 1;
      do_reset();
      drive(1'b1, {2'b11, 2'b00, 4'(code)}, 1'b0, 1'b0, 1'b0);
      repeat (lim) drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      expect_out($sformatf("R3 code %0d at limit", code), lim, 1'b1, 1'b0);
      drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
      expect_out($sformatf("R3 code %0d past limit", code), lim, 1'b1, 1'b1);
    end

    finish_run();
  end
endmodule